// File: doc/BRIEF.md
# Strobe-Paced Sine Oscillator

This block is a numerically controlled oscillator that produces a signed 16-bit sine sample stream. A 16-bit phase register grows by a 16-bit tuning word once per sample strobe, for example a 48 kHz tick taken from a faster system clock. It wraps freely. The nine most significant phase bits address a sine table that is computed when the design is elaborated and held as constant logic. The sample at the output changes only on strobe cycles.

The tuning word has two sources, and the choice is made on a strobe cycle that has the load input high. One source is a fixed constant. The other is an 8-bit control byte, for example a byte taken from a serial receiver, shifted so that it sits at bits [10:3] of the word. When no load is requested the word keeps its value. The table index is taken from the phase before the strobe, so the output trails the phase by one strobe.

Top module: `nco_sine_core`

## Requirements
- R1: While `rst` is high at a rising clock edge, the phase clears to 0, the tuning word becomes 0x0040, the table index clears to 0 and `sample_out` reads 0.
- R2: On a clock edge with `sample_strobe` high, the phase becomes the old phase plus the old tuning word. On any other edge the phase, the index and `sample_out` hold their values.
- R3: On a strobe edge with `load_fcw` high and `use_byte` high (1 = byte source), the tuning word becomes `ctrl_byte` placed at bits [10:3], with bits [15:11] and [2:0] zero. Example: 0xFF gives 0x07F8.
- R4: On a strobe edge with `load_fcw` high and `use_byte` low (0 = fixed source), the tuning word becomes 0x0333.
- R5: When `load_fcw` is low, or on an edge without a strobe, the tuning word keeps its value, and `ctrl_byte` and `use_byte` have no effect.
- R6: On each strobe edge the table index takes phase bits [15:7] from before that edge, so `sample_out` lags the phase by exactly one strobe.
- R7: The phase adds modulo 2^16 and does not saturate.
- R8: The table entry at index i (0 to 511) approximates round(32767·sin(2πi/512)) to within 64 LSB. It is exact at i = 0 and i = 256 (value 0), at i = 128 (value +32767) and at i = 384 (value −32767).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_strobe | input | 1 | One-cycle sample tick that advances the oscillator |
| ctrl_byte | input | 8 | Byte used to form the tuning word in byte mode |
| use_byte | input | 1 | Tuning word source: 1 = byte, 0 = fixed constant |
| load_fcw | input | 1 | Loads the tuning word on a strobe cycle |
| sample_out | output | 16 | Signed sine sample |

## Verification
The bench uses the default parameters: a 16-bit phase, a 9-bit index, 16-bit samples and the byte placed at bit 3. With byte value 0x10 the tuning word is 0x0080, exactly one table step per strobe. A run of 600 strobes therefore visits all 512 entries, including the four exact quadrant points, and carries the phase across the 2^16 wrap. The larger word 0x07F8 and the fixed word 0x0333 step the index unevenly. The default word 0x0040 moves the index only every second strobe, which exposes the one-strobe lag right after reset.

// File: rtl/nco_pkg.sv
package nco_pkg;

    localparam int PHASE_W   = 16;
    localparam int INDEX_W   = 9;
    localparam int SAMPLE_W  = 16;
    localparam int CTRL_W    = 8;
    localparam int CTRL_LSB  = 3;
    localparam logic [PHASE_W-1:0] TUNE_AT_RESET = 16'h0040;
    localparam logic [PHASE_W-1:0] TUNE_FIXED    = 16'h0333;

    typedef enum logic {
        SRC_FIXED = 1'b0,
        SRC_BYTE  = 1'b1
    } tune_src_e;

    // Integer sine approximation over one full period of 'depth' entries.
    // The first half uses a rational fit; the second half mirrors it negated.
    function automatic logic signed [31:0] sine_point(input int unsigned k,
                                                      input int unsigned depth,
                                                      input int unsigned sw);
        longint half;
        longint kk;
        longint p;
        longint amp;
        longint num;
        longint den;
        longint v;
        half = longint'(depth / 2);
        kk   = longint'(k % (depth / 2));
        p    = kk * (half - kk);
        amp  = (longint'(1) <<< (sw - 1)) - 1;
        num  = amp * 16 * p;
        den  = 5 * half * half - 4 * p;
        v    = (num + den / 2) / den;
        if (k >= depth / 2) begin
            v = -v;
        end
        return 32'(v);
    endfunction

endpackage

// File: rtl/nco_tune_reg.sv
module nco_tune_reg
    import nco_pkg::*;
#(
    parameter int PW      = PHASE_W,
    parameter int CW      = CTRL_W,
    parameter int SHIFT   = CTRL_LSB,
    parameter logic [PW-1:0] INIT_WORD  = TUNE_AT_RESET,
    parameter logic [PW-1:0] FIXED_WORD = TUNE_FIXED
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          strobe,
    input  logic          load,
    input  tune_src_e     src,
    input  logic [CW-1:0] ctrl,
    output logic [PW-1:0] tune
);

    logic [PW-1:0] byte_word;
    logic [PW-1:0] next_word;

    always_comb begin
        byte_word = '0;
        byte_word[SHIFT +: CW] = ctrl;
        next_word = (src == SRC_BYTE) ? byte_word : FIXED_WORD;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tune <= INIT_WORD;
        end else if (strobe && load) begin
            tune <= next_word;
        end
    end

endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
    parameter int PW = nco_pkg::PHASE_W,
    parameter int IW = nco_pkg::INDEX_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          strobe,
    input  logic [PW-1:0] tune,
    output logic [PW-1:0] phase,
    output logic [IW-1:0] index
);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= '0;
            index <= '0;
        end else if (strobe) begin
            phase <= phase + tune;
            index <= phase[PW-1 -: IW];
        end
    end

endmodule

// File: rtl/nco_sine_rom.sv
module nco_sine_rom #(
    parameter int IW = nco_pkg::INDEX_W,
    parameter int SW = nco_pkg::SAMPLE_W
) (
    input  logic [IW-1:0]        index,
    output logic signed [SW-1:0] value
);

    localparam int unsigned DEPTH = 1 << IW;

    logic signed [SW-1:0] table_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        localparam logic signed [31:0] ENTRY =
            nco_pkg::sine_point(g, DEPTH, SW);
        assign table_q[g] = SW'(ENTRY);
    end

    assign value = table_q[index];

endmodule

// File: rtl/nco_sine_core.sv
module nco_sine_core
    import nco_pkg::*;
#(
    parameter int PW    = PHASE_W,
    parameter int IW    = INDEX_W,
    parameter int SW    = SAMPLE_W,
    parameter int CW    = CTRL_W,
    parameter int SHIFT = CTRL_LSB
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sample_strobe,
    input  logic [CW-1:0]        ctrl_byte,
    input  logic                 use_byte,
    input  logic                 load_fcw,
    output logic signed [SW-1:0] sample_out
);

    logic [PW-1:0] tune_q;
    logic [PW-1:0] phase_q;
    logic [IW-1:0] index_q;
    tune_src_e     src;

    assign src = use_byte ? SRC_BYTE : SRC_FIXED;

    nco_tune_reg #(
        .PW(PW), .CW(CW), .SHIFT(SHIFT),
        .INIT_WORD(PW'(TUNE_AT_RESET)), .FIXED_WORD(PW'(TUNE_FIXED))
    ) u_tune (
        .clk(clk), .rst(rst), .strobe(sample_strobe), .load(load_fcw),
        .src(src), .ctrl(ctrl_byte), .tune(tune_q)
    );

    nco_phase_acc #(.PW(PW), .IW(IW)) u_acc (
        .clk(clk), .rst(rst), .strobe(sample_strobe), .tune(tune_q),
        .phase(phase_q), .index(index_q)
    );

    nco_sine_rom #(.IW(IW), .SW(SW)) u_rom (
        .index(index_q), .value(sample_out)
    );

endmodule

// File: rtl/nco_sine_core_chk.sv
module nco_sine_core_chk #(
    parameter int PW    = nco_pkg::PHASE_W,
    parameter int IW    = nco_pkg::INDEX_W,
    parameter int SW    = nco_pkg::SAMPLE_W,
    parameter int CW    = nco_pkg::CTRL_W,
    parameter int SHIFT = nco_pkg::CTRL_LSB
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 sample_strobe,
    input logic [CW-1:0]        ctrl_byte,
    input logic                 use_byte,
    input logic                 load_fcw,
    input logic [PW-1:0]        tune,
    input logic [PW-1:0]        phase,
    input logic [IW-1:0]        index,
    input logic signed [SW-1:0] sample_out
);

    p_reset_r1: assert property (@(posedge clk)
        rst |=> (phase == '0 && index == '0 && tune == PW'(nco_pkg::TUNE_AT_RESET)));

    p_step_r2: assert property (@(posedge clk) disable iff (rst)
        sample_strobe |=> phase == PW'($past(phase) + $past(tune)));

    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !sample_strobe |=> ($stable(phase) && $stable(index) && $stable(sample_out)));

    p_byte_word_r3: assert property (@(posedge clk) disable iff (rst)
        (sample_strobe && load_fcw && use_byte) |=>
            (tune[SHIFT +: CW] == $past(ctrl_byte)
             && (tune >> (SHIFT + CW)) == '0
             && tune[SHIFT-1:0] == '0));

    p_fixed_word_r4: assert property (@(posedge clk) disable iff (rst)
        (sample_strobe && load_fcw && !use_byte) |=> tune == PW'(nco_pkg::TUNE_FIXED));

    p_keep_word_r5: assert property (@(posedge clk) disable iff (rst)
        !(sample_strobe && load_fcw) |=> $stable(tune));

    p_index_lag_r6: assert property (@(posedge clk) disable iff (rst)
        sample_strobe |=> index == $past(phase[PW-1 -: IW]));

endmodule

bind nco_sine_core nco_sine_core_chk #(
    .PW(PW), .IW(IW), .SW(SW), .CW(CW), .SHIFT(SHIFT)
) u_chk (
    .clk(clk), .rst(rst), .sample_strobe(sample_strobe),
    .ctrl_byte(ctrl_byte), .use_byte(use_byte), .load_fcw(load_fcw),
    .tune(tune_q), .phase(phase_q), .index(index_q), .sample_out(sample_out)
);

// File: tb/sim_nco_sine_core.sv
`timescale 1ns/1ps
module sim_nco_sine_core;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               sample_strobe = 1'b0;
    logic [7:0]         ctrl_byte = 8'h00;
    logic               use_byte = 1'b0;
    logic               load_fcw = 1'b0;
    logic signed [15:0] sample_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // bench model state, derived from the requirements
    logic [15:0] m_phase;
    logic [15:0] m_tune;
    logic [8:0]  m_index;

    always #2.5 clk = ~clk;

    nco_sine_core u0 (
        .clk(clk), .rst(rst), .sample_strobe(sample_strobe),
        .ctrl_byte(ctrl_byte), .use_byte(use_byte), .load_fcw(load_fcw),
        .sample_out(sample_out)
    );

    function automatic int ideal_sine(input int i);
        real r;
        r = 32767.0 * $sin(2.0 * 3.14159265358979 * real'(i) / 512.0);
        return int'(r);
    endfunction

    task automatic check_int(input string req, input string what, input int act, input int exp, input int tol);
        int d;
        n_checks++;
        d = act - exp;
        if (d < 0) d = -d;
        if (d > tol) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d (tol %0d)", req, what, act, exp, tol);
        end
    endtask

    task automatic check_sample(input string req);
        int tol;
        tol = (m_index % 128 == 0) ? 0 : 64;
        check_int(req, "sample", int'(sample_out), ideal_sine(int'(m_index)), tol);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; sample_strobe = 1'b0; load_fcw = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_phase = 16'h0000; m_tune = 16'h0040; m_index = 9'd0;
    endtask

    task automatic strobe_once(input logic ld, input logic sel, input logic [7:0] b);
        @(negedge clk);
        sample_strobe = 1'b1; load_fcw = ld; use_byte = sel; ctrl_byte = b;
        m_index = m_phase[15:7];
        m_phase = m_phase + m_tune;
        if (ld) m_tune = sel ? {5'b0, b, 3'b000} : 16'h0333;
        @(negedge clk);
        sample_strobe = 1'b0; load_fcw = 1'b0;
    endtask

    task automatic t_reset_r1();
        do_reset();
        check_int("R1", "sample after reset", int'(sample_out), 0, 0);
        // lag: first strobe moves phase 0 -> 0x40 but index stays 0
        strobe_once(1'b0, 1'b0, 8'h00);
        check_int("R6", "sample one strobe after reset", int'(sample_out), 0, 0);
        strobe_once(1'b0, 1'b0, 8'h00);
        check_int("R6", "index still 0 at phase 0x40", int'(sample_out), 0, 0);
        strobe_once(1'b0, 1'b0, 8'h00);
        check_sample("R2");
    endtask

    task automatic t_default_rate_r2();
        for (int i = 0; i < 10; i++) begin
            strobe_once(1'b0, 1'b0, 8'h00);
            check_sample("R2");
        end
    endtask

    task automatic t_idle_r5();
        logic signed [15:0] held;
        held = sample_out;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            load_fcw = 1'b1; use_byte = i[0]; ctrl_byte = 8'(8'hA5 + i);
            @(negedge clk);
            load_fcw = 1'b0;
            check_int("R2", "sample held without strobe", int'(sample_out), int'(held), 0);
        end
        // word must be unchanged: stepping follows the old word
        for (int i = 0; i < 6; i++) begin
            strobe_once(1'b0, i[0], 8'hFF);
            check_sample("R5");
        end
    endtask

    task automatic t_fixed_r4();
        strobe_once(1'b1, 1'b0, 8'h77);
        check_sample("R4");
        for (int i = 0; i < 20; i++) begin
            strobe_once(1'b0, 1'b1, 8'h3C);
            check_sample("R4");
        end
    endtask

    task automatic t_byte_r3();
        strobe_once(1'b1, 1'b1, 8'hFF);
        check_sample("R3");
        for (int i = 0; i < 40; i++) begin
            strobe_once(1'b0, 1'b0, 8'h00);
            check_sample("R3");
        end
    endtask

    task automatic t_sweep_r7_r8();
        do_reset();
        // byte 0x10 -> word 0x0080: one table step per strobe
        strobe_once(1'b1, 1'b1, 8'h10);
        check_sample("R8");
        for (int i = 0; i < 600; i++) begin
            strobe_once(1'b0, 1'b0, 8'h00);
            check_sample((i > 512) ? "R7" : "R8");
        end
    endtask

    initial begin
        t_reset_r1();
        t_default_rate_r2();
        t_idle_r5();
        t_fixed_r4();
        t_byte_r3();
        t_sweep_r7_r8();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule